// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits on the host side of a shared asynchronous parallel EPROM bus. It takes a request carrying a device index and a word address, drives the address and that device's active-low chip select, asserts the common active-low output strobe after a computed delay, and latches the 16-bit data word once every access time has elapsed. It then pulses a valid flag with the word and releases both strobes on the same clock edge.

All timing is fixed when the design is elaborated. A speed-grade parameter selects the address-access, strobe-access and output-float times in nanoseconds. Each time is turned into clock cycles by rounding up against the clock-period parameter. The output strobe is held back by the access time minus the strobe-access time, so it is active only as long as the read needs. When the next access goes to a different device, a float gap keeps the new chip select inactive until the previous device has let go of the data lines. An access to the same device skips this gap.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it, every chip select and the output strobe are high (inactive), and busy and valid are low.
- R2: A request is taken only while the controller is idle. A request raised while busy has no effect on the address, device or data of the access in flight, and it starts no extra access.
- R3: On the clock edge that starts an access, the address output takes the requested word address. Exactly one chip select goes low: bit d of the select bus belongs to device index d. All other selects stay high.
- R4: The output strobe goes low exactly OE_DLY = max(ACC_CYC - OE_CYC, 0) cycles after the chip select goes low. It is never low while every chip select is high.
- R5: The data word is latched WAIT_CYC = max(ACC_CYC, OE_DLY + OE_CYC, 1) cycles after the chip select goes low. On that same edge valid pulses high for one cycle with the word, and the chip select and output strobe return high.
- R6: Busy is high from the cycle after a request is taken until the valid pulse. Busy is low while valid is high.
- R7: When the new access targets a different device than the last completed one, its chip select goes low no earlier than DF_CYC cycles after the previous release. A request issued in the valid cycle therefore completes in WAIT_CYC + DF_CYC cycles, measured from the cycle after the valid pulse. Chip selects never pass directly from one device to another.
- R8: A request to the same device, issued in the valid cycle, starts at once with no float gap.
- R9: Each cycle count is ceil(time_ns / CLK_PERIOD_NS). The speed grades 0..6 give access times of 55/70/90/120/150/200/250 ns, strobe-access times of 40/40/45/50/65/75/75 ns and float times of 30/30/40/50/50/50/50 ns. With the defaults (10 ns clock, grade 0) this gives ACC_CYC 6, OE_CYC 4, OE_DLY 2, WAIT_CYC 6 and DF_CYC 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, taken when idle |
| req_dev_i | input | DEV_W | Device index for the request |
| req_addr_i | input | ADDR_W | Word address for the request |
| busy_o | output | 1 | Access in progress |
| rvalid_o | output | 1 | One-cycle pulse with the read word |
| rdata_o | output | DATA_W | Latched read word |
| mem_addr_o | output | ADDR_W | Address to the EPROM bus |
| mem_ce_n_o | output | NUM_DEV | Per-device chip select, active low |
| mem_oe_n_o | output | 1 | Common output strobe, active low |
| mem_data_i | input | DATA_W | Data from the EPROM bus |

## Verification
The bench models the EPROM bus in cycles. It returns garbage unless the chip select, the output strobe and the address have each been stable for their full times. A controller that samples one cycle early, or releases the strobes before it latches, therefore reads a wrong word. The bench also tracks how long the selects stay high between accesses, so a missing or short float gap on a device change is reported, and so is a gap wrongly inserted for the same device. Requests raised mid-access check that a controller which re-latches its inputs while busy returns the wrong word or starts a stray access.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GAP    = 2'd1,
        ST_ACCESS = 2'd2
    } rd_state_e;

    // Address (and chip-select) access time per speed grade, ns
    function automatic int grade_acc_ns(input int g);
        case (g)
            0: return 55;
            1: return 70;
            2: return 90;
            3: return 120;
            4: return 150;
            5: return 200;
            default: return 250;
        endcase
    endfunction

    // Output-strobe access time per speed grade, ns
    function automatic int grade_oe_ns(input int g);
        case (g)
            0, 1: return 40;
            2: return 45;
            3: return 50;
            4: return 65;
            default: return 75;
        endcase
    endfunction

    // Output float time after strobe release per speed grade, ns
    function automatic int grade_float_ns(input int g);
        case (g)
            0, 1: return 30;
            2: return 40;
            default: return 50;
        endcase
    endfunction

    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eprom_rd_cedec.sv
module eprom_rd_cedec #(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic               en_i,
    input  logic [DEV_W-1:0]   dev_i,
    output logic [NUM_DEV-1:0] ce_n_o
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign ce_n_o[i] = !(en_i && (dev_i == DEV_W'(i)));
    end
endmodule

// File: rtl/eprom_rd_float.sv
module eprom_rd_float #(
    parameter int FLT_CYC = 3,
    parameter int FLT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [FLT_W-1:0] cnt_o
);
    logic [FLT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = FLT_W'(FLT_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - FLT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int NUM_DEV       = 4,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 16,
    localparam int DEV_W        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [DEV_W-1:0]   req_dev_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output logic               busy_o,
    output logic               rvalid_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [NUM_DEV-1:0] mem_ce_n_o,
    output logic               mem_oe_n_o,
    input  logic [DATA_W-1:0]  mem_data_i
);
    localparam int ACC_CYC  = ns_to_cyc(grade_acc_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int CE_CYC   = ACC_CYC;
    localparam int OE_CYC   = ns_to_cyc(grade_oe_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int OE_DLY   = max_int(ACC_CYC - OE_CYC, 0);
    localparam int WAIT_CYC = max_int(max_int(max_int(ACC_CYC, CE_CYC), OE_DLY + OE_CYC), 1);
    localparam int DF_CYC   = max_int(ns_to_cyc(grade_float_ns(SPEED_GRADE), CLK_PERIOD_NS), 1);
    localparam int CNT_W    = $clog2(WAIT_CYC + 1);
    localparam int FLT_W    = $clog2(DF_CYC + 1);

    typedef struct packed {
        rd_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [DEV_W-1:0]   dev;
        logic [DEV_W-1:0]   last_dev;
        logic [ADDR_W-1:0]  addr;
        logic               ce_en;
        logic               oe_en;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic [FLT_W-1:0] flt_cnt;
    logic             release_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             flt_busy;

    assign cnt_inc  = ctl_q.cnt + CNT_W'(1);
    assign flt_busy = (flt_cnt > FLT_W'(1));

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        release_d    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.dev  = req_dev_i;
                    ctl_d.addr = req_addr_i;
                    ctl_d.cnt  = '0;
                    if ((req_dev_i != ctl_q.last_dev) && flt_busy) begin
                        ctl_d.state = ST_GAP;
                    end else begin
                        ctl_d.state = ST_ACCESS;
                        ctl_d.ce_en = 1'b1;
                        ctl_d.oe_en = (OE_DLY == 0);
                    end
                end
            end
            ST_GAP: begin
                if (!flt_busy) begin
                    ctl_d.state = ST_ACCESS;
                    ctl_d.ce_en = 1'b1;
                    ctl_d.oe_en = (OE_DLY == 0);
                    ctl_d.cnt   = '0;
                end
            end
            ST_ACCESS: begin
                ctl_d.cnt = cnt_inc;
                if (cnt_inc == CNT_W'(OE_DLY)) begin
                    ctl_d.oe_en = 1'b1;
                end
                if (ctl_q.cnt == CNT_W'(WAIT_CYC - 1)) begin
                    ctl_d.rdata    = mem_data_i;
                    ctl_d.rvalid   = 1'b1;
                    ctl_d.ce_en    = 1'b0;
                    ctl_d.oe_en    = 1'b0;
                    ctl_d.last_dev = ctl_q.dev;
                    ctl_d.state    = ST_IDLE;
                    release_d      = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ce_en = 1'b0;
                ctl_d.oe_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    eprom_rd_float #(
        .FLT_CYC (DF_CYC),
        .FLT_W   (FLT_W)
    ) u_float (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (release_d),
        .cnt_o  (flt_cnt)
    );

    eprom_rd_cedec #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_cedec (
        .en_i   (ctl_q.ce_en),
        .dev_i  (ctl_q.dev),
        .ce_n_o (mem_ce_n_o)
    );

    assign busy_o     = (ctl_q.state != ST_IDLE);
    assign rvalid_o   = ctl_q.rvalid;
    assign rdata_o    = ctl_q.rdata;
    assign mem_addr_o = ctl_q.addr;
    assign mem_oe_n_o = !ctl_q.oe_en;

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int NUM_DEV       = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_i,
    input logic               busy_o,
    input logic               rvalid_o,
    input logic [NUM_DEV-1:0] mem_ce_n_o,
    input logic               mem_oe_n_o
);
    localparam int DF_CYC = max_int(ns_to_cyc(grade_float_ns(SPEED_GRADE), CLK_PERIOD_NS), 1);
    localparam int HW     = $clog2(DF_CYC + 2);

    logic [NUM_DEV-1:0] sel;
    logic [NUM_DEV-1:0] last_sel_q;
    logic [HW-1:0]      hi_cnt_q;

    assign sel = ~mem_ce_n_o;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sel_q <= '0;
            hi_cnt_q   <= '0;
        end else begin
            if (sel != '0) begin
                last_sel_q <= sel;
                hi_cnt_q   <= '0;
            end else if (hi_cnt_q < HW'(DF_CYC)) begin
                hi_cnt_q <= hi_cnt_q + HW'(1);
            end
        end
    end

    assert_ce_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    assert_oe_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> (sel != '0));

    assert_release_on_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ((sel == '0) && mem_oe_n_o && ($past(sel) != '0)));

    assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !busy_o);

    assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));

    assert_no_direct_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != '0) && ($past(sel) != '0)) |-> (sel == $past(sel)));

    assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != '0) && ($past(sel) == '0) && (last_sel_q != '0) && (sel != last_sel_q))
            |-> (hi_cnt_q >= HW'(DF_CYC)));

endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .SPEED_GRADE   (SPEED_GRADE),
    .NUM_DEV       (NUM_DEV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .busy_o     (busy_o),
    .rvalid_o   (rvalid_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_oe_n_o (mem_oe_n_o)
);

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;
    // Expected cycle counts for a 10 ns clock, grade 0 (R9)
    localparam int T_ACC  = (55 + 9) / 10;
    localparam int T_OE   = (40 + 9) / 10;
    localparam int T_DLY  = T_ACC - T_OE;
    localparam int T_WAIT = T_ACC;
    localparam int T_DF   = (30 + 9) / 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_dev = '0;
    logic [15:0] req_addr = '0;
    logic        busy, rvalid;
    logic [15:0] rdata, mem_addr, mem_data;
    logic [3:0]  ce_n;
    logic        oe_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eprom_rd_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_dev_i  (req_dev),
        .req_addr_i (req_addr),
        .busy_o     (busy),
        .rvalid_o   (rvalid),
        .rdata_o    (rdata),
        .mem_addr_o (mem_addr),
        .mem_ce_n_o (ce_n),
        .mem_oe_n_o (oe_n),
        .mem_data_i (mem_data)
    );

    function automatic logic [15:0] pat(input int d, input logic [15:0] a);
        return (a * 16'd3) ^ {d[1:0], 14'h0} ^ 16'h5A5A;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- bus model, updated 1 ns after each edge ----------------
    int          ce_cnt = 0, oe_cnt = 0, ad_cnt = 0, hi_cnt = 0;
    logic [3:0]  sel_prev = '0, last_sel = '0;
    logic        oe_prev = 1'b1;
    logic [15:0] addr_prev = '0;
    int          act_dev;

    always_comb begin
        act_dev = -1;
        for (int i = 0; i < 4; i++) if (!ce_n[i] && (ce_n | (4'b1 << i)) == 4'hF) act_dev = i;
    end

    assign mem_data = (act_dev >= 0 && ce_cnt >= T_ACC && oe_cnt >= T_OE && ad_cnt >= T_ACC)
                      ? pat(act_dev, mem_addr) : 16'hDEAD;

    always @(posedge clk) begin
        logic [3:0] s;
        #1;
        s = ~ce_n;
        if (rst_n) begin
            if (s != 0 && sel_prev == 0 && last_sel != 0 && s != last_sel)
                chk(hi_cnt >= T_DF, "R7 float gap", hi_cnt, T_DF);
        end
        if (s != 0 && s == sel_prev) ce_cnt++;
        else if (s != 0)             ce_cnt = 1;
        else                         ce_cnt = 0;
        oe_cnt = oe_n ? 0 : oe_cnt + 1;
        ad_cnt = (mem_addr == addr_prev) ? ad_cnt + 1 : 1;
        if (rst_n && !oe_n && oe_prev)
            chk(ce_cnt == T_DLY + 1, "R4 oe delay", ce_cnt, T_DLY + 1);
        hi_cnt = (s == 0) ? hi_cnt + 1 : 0;
        if (s != 0) last_sel = s;
        sel_prev  = s;
        oe_prev   = oe_n;
        addr_prev = mem_addr;
    end

    // One read; called and returns at a falling edge
    task automatic do_read(input int d, input logic [15:0] a, input int exp_lat, input string rq);
        int lat;
        req = 1'b1; req_dev = d[1:0]; req_addr = a;
        @(posedge clk); #1;
        req = 1'b0;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1 && exp_lat == T_WAIT + 1) begin
                chk(ce_n == ~(4'b1 << d), "R3 select", ce_n, ~(4'b1 << d));
                chk(mem_addr == a, "R3 address", mem_addr, a);
                chk(busy, "R6 busy during access", busy, 1);
            end
            if (rvalid || lat > 40) break;
        end
        chk(lat == exp_lat, rq, lat, exp_lat);
        chk(rdata == pat(d, a), "R5 data", rdata, pat(d, a));
        chk(!busy && ce_n == 4'hF && oe_n, "R5/R6 release", {busy, ce_n, oe_n}, 6'b0_1111_1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n == 4'hF && oe_n && !busy && !rvalid, "R1 reset", {ce_n, oe_n, busy, rvalid}, 7'b1111_1_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n == 4'hF && oe_n && !busy && !rvalid, "R1 after reset", {ce_n, oe_n, busy, rvalid}, 7'b1111_1_0_0);

        // Sweep of devices and addresses, isolated reads (R3, R4, R5, R9)
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 18; k++) begin
                logic [15:0] a;
                a = (k == 16) ? 16'h0000 : (k == 17) ? 16'hFFFF : (16'h1 << k);
                idle(T_DF + 2);
                do_read(d, a, T_WAIT + 1, "R9 isolated latency");
            end
        end

        // Back-to-back pairs: different device pays the float gap (R7), same does not (R8)
        for (int a0 = 0; a0 < 4; a0++) begin
            for (int b0 = 0; b0 < 4; b0++) begin
                idle(T_DF + 2);
                do_read(a0, 16'h1234 + 16'(a0), T_WAIT + 1, "R9 latency");
                if (a0 == b0) do_read(b0, 16'hBEEF, T_WAIT + 1, "R8 same device latency");
                else          do_read(b0, 16'hBEEF, T_WAIT + T_DF, "R7 device switch latency");
            end
        end

        // Request while busy is ignored (R2)
        idle(T_DF + 2);
        req = 1'b1; req_dev = 2'd1; req_addr = 16'h0F0F;
        @(posedge clk); #1;
        req = 1'b0;
        @(negedge clk); @(negedge clk);
        req = 1'b1; req_dev = 2'd3; req_addr = 16'hA5A5;
        @(negedge clk);
        req = 1'b0;
        while (!rvalid) @(negedge clk);
        chk(rdata == pat(1, 16'h0F0F), "R2 ignored request data", rdata, pat(1, 16'h0F0F));
        chk(mem_addr == 16'h0F0F, "R2 ignored request address", mem_addr, 16'h0F0F);
        @(negedge clk);
        chk(!busy && ce_n == 4'hF, "R2 no stray access", {busy, ce_n}, 5'b0_1111);

        idle(4);
        done = 1'b1;
        finish_run();
    end
endmodule